// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects up to eight edge-signalled interrupt requests and presents one of them at a time to a processor. Software programs it through a single byte-wide write path that has two destinations: a command port and a data port. A command byte with bit 4 set begins a short setup sequence. The data-port bytes that follow set the vector base, then the cascade setting, then the mode setting. Once that sequence is complete, data-port bytes load the line mask.

A rising edge on a request line latches a pending request. The controller picks the highest-priority request that is unmasked, where line 0 has the highest priority. It raises its interrupt output only when no line of equal or higher priority is already in service. When the processor acknowledges, the controller returns a vector made from the programmed base with the line number in its low bits. It also moves that line from pending to in service. The end-of-interrupt command byte 0x20 releases the highest-priority line in service.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, int_req and vec_valid are 0.
- R2: A command-port byte with bit 4 set starts setup. In the same step it clears all pending bits, all in-service bits and the mask, and the next data-port byte is taken as the vector base.
- R3: A vector delivered on acknowledge has bits 7..3 equal to bits 7..3 of the base byte, and bits 2..0 equal to the granted line number.
- R4: During setup, the byte after the base is the cascade byte, unless bit 1 of the setup command was 1. The mode byte comes next, and only if bit 0 of the setup command was 1. Every later data-port byte goes to the mask.
- R5: After setup, a data-port byte loads the mask, and bit i = 1 blocks line i. A blocked request stays pending and is presented once it is unblocked. Data-port bytes written before setup has begun do not change the mask.
- R6: A 0-to-1 change on a request line sets its pending bit. Holding the line high does not set the bit again after it has been cleared.
- R7: Line 0 has the highest priority. int_req is 1 only when setup is complete, some line is pending and unmasked, and no line at the same or higher priority than the best such line is in service.
- R8: int_ack while int_req is 1 gives vec_valid = 1 with the vector one cycle later, clears the granted line's pending bit and sets its in-service bit. int_ack while int_req is 0 is ignored.
- R9: The command byte 0x20 clears the highest-priority in-service bit. Other command bytes with bit 4 clear change nothing.
- R10: int_req stays 0 until the setup sequence has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_cmd | input | 1 | 1 selects the command port, 0 the data port |
| wr_data | input | 8 | Byte written |
| irq_in | input | NUM_LINES | Request lines, rising-edge sensitive |
| int_ack | input | 1 | Processor acknowledge, one-cycle pulse |
| int_req | output | 1 | Interrupt to the processor |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec_out | output | 8 | Vector number |

## Verification
A request edge is sampled at a clock edge, and int_req reflects it in the same cycle that follows that edge. Mask writes, end-of-interrupt commands and setup commands likewise take effect one edge after they are written. The vector and vec_valid appear in the cycle after the acknowledge edge. The bench drives each input just after a falling edge, lets exactly one rising edge pass, and then compares every output with a reference model at the next falling edge. Directed setup, priority and masking cases run first, followed by seeded random traffic.

// File: rtl/irq_vector_pkg.sv
package irq_vector_pkg;
   localparam int BYTE_W    = 8;
   localparam int SETUP_BIT = 4;
   localparam int SOLO_BIT  = 1;
   localparam int MODE_BIT  = 0;
   localparam logic [BYTE_W-1:0] EOI_BYTE = 8'h20;

   typedef enum logic [2:0] {
      CFG_IDLE,
      CFG_BASE,
      CFG_CASC,
      CFG_MODE,
      CFG_RUN
   } cfg_state_e;

   typedef struct packed {
      logic is_setup;
      logic is_eoi;
   } cmd_dec_t;

   function automatic cmd_dec_t decode_cmd(input logic [BYTE_W-1:0] b);
      cmd_dec_t d;
      d.is_setup = b[SETUP_BIT];
      d.is_eoi   = (b == EOI_BYTE);
      return d;
   endfunction
endpackage

// File: rtl/ivc_prio_find.sv
module ivc_prio_find #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     vec,
   output logic             found,
   output logic [IDX_W-1:0] idx,
   output logic [N-1:0]     onehot
);
   always_comb begin
      found  = 1'b0;
      idx    = '0;
      onehot = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            found  = 1'b1;
            idx    = i[IDX_W-1:0];
            onehot = '0;
            onehot[i] = 1'b1;
         end
      end
   end

   // R7: the pick is a single set bit of the input
   p_pick_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(onehot) && (found == ((vec & onehot) != '0)));
endmodule

// File: rtl/ivc_cfg_seq.sv
module ivc_cfg_seq
   import irq_vector_pkg::*;
#(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    wr_cmd,
   input  logic [BYTE_W-1:0]       wr_data,
   output logic                    ready,
   output logic                    setup_pulse,
   output logic                    eoi_pulse,
   output logic [BYTE_W-1:IDX_W]   base_hi,
   output logic [N-1:0]            mask
);
   cfg_state_e state_q;
   logic       solo_q, want_mode_q;
   cmd_dec_t   dec;

   always_comb dec = decode_cmd(wr_data);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= CFG_IDLE;
         solo_q      <= 1'b0;
         want_mode_q <= 1'b0;
         base_hi     <= '0;
         mask        <= '0;
      end else if (wr_en) begin
         if (wr_cmd) begin
            if (dec.is_setup) begin
               state_q     <= CFG_BASE;
               solo_q      <= wr_data[SOLO_BIT];
               want_mode_q <= wr_data[MODE_BIT];
               mask        <= '0;
            end
         end else begin
            case (state_q)
               CFG_BASE: begin
                  base_hi <= wr_data[BYTE_W-1:IDX_W];
                  if (!solo_q)          state_q <= CFG_CASC;
                  else if (want_mode_q) state_q <= CFG_MODE;
                  else                  state_q <= CFG_RUN;
               end
               CFG_CASC: state_q <= want_mode_q ? CFG_MODE : CFG_RUN;
               CFG_MODE: state_q <= CFG_RUN;
               CFG_RUN:  mask    <= wr_data[N-1:0];
               default:  ;
            endcase
         end
      end
   end

   assign ready       = (state_q == CFG_RUN);
   assign setup_pulse = wr_en && wr_cmd && dec.is_setup;
   assign eoi_pulse   = wr_en && wr_cmd && dec.is_eoi;

   // R5: data bytes outside the running state leave the mask alone
   p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_cmd && state_q != CFG_RUN) |=> $stable(mask));
   // R2: a setup command restarts the sequence with an open mask
   p_setup_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
      setup_pulse |=> (state_q == CFG_BASE && mask == '0));
endmodule

// File: rtl/ivc_irq_state.sv
module ivc_irq_state #(
   parameter int N = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] irq_in,
   input  logic         clr_all,
   input  logic         ack_fire,
   input  logic [N-1:0] ack_oh,
   input  logic         eoi,
   input  logic [N-1:0] eoi_oh,
   output logic [N-1:0] irr,
   output logic [N-1:0] isr
);
   logic [N-1:0] prev_q;
   logic [N-1:0] rise;

   assign rise = irq_in & ~prev_q;

   for (genvar i = 0; i < N; i++) begin : g_line
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q[i] <= 1'b0;
            irr[i]    <= 1'b0;
            isr[i]    <= 1'b0;
         end else begin
            prev_q[i] <= irq_in[i];
            if (clr_all) begin
               irr[i] <= 1'b0;
               isr[i] <= 1'b0;
            end else begin
               irr[i] <= rise[i] | (irr[i] & ~(ack_fire & ack_oh[i]));
               isr[i] <= (isr[i] | (ack_fire & ack_oh[i])) & ~(eoi & eoi_oh[i]);
            end
         end
      end
   end

   // R6: every detected edge is latched as pending
   p_edge_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_all && rise != '0) |=> ((irr & $past(rise)) == $past(rise)));
   // R8: a granted line is in service afterwards
   p_grant_marks_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_fire && !clr_all) |=> ((isr & $past(ack_oh)) == $past(ack_oh)));
   // R9: end of interrupt releases the chosen line
   p_eoi_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi && !clr_all) |=> ((isr & $past(eoi_oh)) == '0));
endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
   import irq_vector_pkg::*;
#(
   parameter int NUM_LINES = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic                  wr_cmd,
   input  logic [7:0]            wr_data,
   input  logic [NUM_LINES-1:0]  irq_in,
   input  logic                  int_ack,
   output logic                  int_req,
   output logic                  vec_valid,
   output logic [7:0]            vec_out
);
   localparam int IDX_W = $clog2(NUM_LINES);

   initial begin
      if (NUM_LINES < 2 || NUM_LINES > BYTE_W || (1 << IDX_W) != NUM_LINES)
         $fatal(1, "NUM_LINES must be a power of two from 2 to %0d", BYTE_W);
   end

   logic                   ready, setup_pulse, eoi_pulse;
   logic [BYTE_W-1:IDX_W]  base_hi;
   logic [NUM_LINES-1:0]   mask, irr, isr, pending;
   logic                   pend_found, isr_found, blocked, ack_fire;
   logic [IDX_W-1:0]       pend_idx, isr_idx;
   logic [NUM_LINES-1:0]   pend_oh, isr_oh;

   ivc_cfg_seq #(.N(NUM_LINES), .IDX_W(IDX_W)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
      .ready(ready), .setup_pulse(setup_pulse), .eoi_pulse(eoi_pulse),
      .base_hi(base_hi), .mask(mask)
   );

   ivc_irq_state #(.N(NUM_LINES)) u_state (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .clr_all(setup_pulse),
      .ack_fire(ack_fire), .ack_oh(pend_oh), .eoi(eoi_pulse), .eoi_oh(isr_oh),
      .irr(irr), .isr(isr)
   );

   assign pending = irr & ~mask;

   ivc_prio_find #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pend_pick (
      .clk(clk), .rst_n(rst_n), .vec(pending),
      .found(pend_found), .idx(pend_idx), .onehot(pend_oh)
   );

   ivc_prio_find #(.N(NUM_LINES), .IDX_W(IDX_W)) u_isr_pick (
      .clk(clk), .rst_n(rst_n), .vec(isr),
      .found(isr_found), .idx(isr_idx), .onehot(isr_oh)
   );

   assign blocked  = isr_found && (isr_idx <= pend_idx);
   assign int_req  = ready && pend_found && !blocked;
   assign ack_fire = int_ack && int_req;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else begin
         vec_valid <= ack_fire;
         if (ack_fire) vec_out <= {base_hi, pend_idx};
      end
   end

   // R8: an accepted acknowledge yields a vector on the next cycle
   p_ack_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (int_ack && int_req) |=> vec_valid);
   // R8: no vector without an accepted acknowledge
   p_no_stray_vector_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(int_ack && int_req) |=> !vec_valid);
   // R3: the upper vector bits come from the programmed base
   p_vector_base_r3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_out[BYTE_W-1:IDX_W] == $past(base_hi)));
endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, wr_cmd = 1'b0, int_ack = 1'b0;
   logic [7:0] wr_data = '0, irq_in = '0;
   logic       int_req, vec_valid;
   logic [7:0] vec_out;

   int checks = 0, errors = 0;
   bit done = 0;

   // model state
   logic [7:0] m_irr = '0, m_isr = '0, m_mask = '0, m_base = '0, m_prev = '0;
   int         m_state = 0; // 0 idle,1 base,2 cascade,3 mode,4 run
   logic       m_solo = 0, m_mode = 0;
   logic       e_valid = 0;
   logic [7:0] e_vec = '0;

   always #2.5 clk = ~clk;

   irq_vector_ctrl u_irq_vector_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
      .irq_in(irq_in), .int_ack(int_ack), .int_req(int_req),
      .vec_valid(vec_valid), .vec_out(vec_out)
   );

   function automatic int low_idx(input logic [7:0] v);
      for (int i = 0; i < 8; i++) if (v[i]) return i;
      return 8;
   endfunction

   function automatic logic m_int();
      logic [7:0] p = m_irr & ~m_mask;
      if (m_state != 4 || p == 0) return 1'b0;
      return (low_idx(m_isr) > low_idx(p));
   endfunction

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic model_edge(input logic we, input logic cmd, input logic [7:0] d,
                             input logic a, input logic [7:0] irq);
      logic       ack_ok = a && m_int();
      logic [7:0] p = m_irr & ~m_mask;
      logic [7:0] abit = '0, ebit = '0, rise;
      if (ack_ok) abit[low_idx(p)] = 1'b1;
      if (we && cmd && d == 8'h20 && m_isr != 0) ebit[low_idx(m_isr)] = 1'b1;
      e_valid = ack_ok;
      if (ack_ok) e_vec = {m_base[7:3], 3'(low_idx(p))};
      rise   = irq & ~m_prev;
      m_prev = irq;
      m_irr  = (m_irr & ~abit) | rise;
      m_isr  = (m_isr | abit) & ~ebit;
      if (we && cmd && d[4]) begin
         m_irr = '0; m_isr = '0; m_mask = '0; m_state = 1;
         m_solo = d[1]; m_mode = d[0];
      end else if (we && !cmd) begin
         case (m_state)
            1: begin m_base = d; m_state = !m_solo ? 2 : (m_mode ? 3 : 4); end
            2: m_state = m_mode ? 3 : 4;
            3: m_state = 4;
            4: m_mask = d;
            default: ;
         endcase
      end
   endtask

   task automatic step(input string tag, input logic we, input logic cmd,
                       input logic [7:0] d, input logic a, input logic [7:0] irq);
      wr_en = we; wr_cmd = cmd; wr_data = d; int_ack = a; irq_in = irq;
      @(posedge clk);
      model_edge(we, cmd, d, a, irq);
      @(negedge clk);
      wr_en = 0; int_ack = 0;
      chk({tag, " int_req"}, {7'd0, int_req}, {7'd0, m_int()});
      chk({tag, " vec_valid"}, {7'd0, vec_valid}, {7'd0, e_valid});
      if (e_valid) chk({tag, " vector"}, vec_out, e_vec);
   endtask

   task automatic idle(input string tag, input int n);
      for (int i = 0; i < n; i++) step(tag, 0, 0, 8'h00, 0, irq_in);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd24681));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 int_req", {7'd0, int_req}, 8'h00);
      chk("R1 vec_valid", {7'd0, vec_valid}, 8'h00);

      // R10 requests before setup are not presented
      step("R10 early edge", 0, 0, 8'h00, 0, 8'h08);
      step("R5 early mask write", 0, 0, 8'hFF, 0, 8'h08);
      step("R10 early ack", 0, 0, 8'h00, 1, 8'h00);

      // R2 full setup sequence
      step("R2 setup cmd", 1, 1, 8'h11, 0, 8'h00);
      step("R2 base", 1, 0, 8'h20, 0, 8'h00);
      step("R10 mid setup edge", 0, 0, 8'h00, 0, 8'h01);
      step("R4 cascade byte", 1, 0, 8'h04, 0, 8'h01);
      step("R4 mode byte", 1, 0, 8'h01, 0, 8'h01);
      chk("R10 pending after setup", {7'd0, int_req}, 8'h01);
      step("R5 mask only line 0", 1, 0, 8'hFE, 0, 8'h00);
      step("R3 ack line 0", 0, 0, 8'h00, 1, 8'h00);
      chk("R3 vector 0x20", vec_out, 8'h20);
      step("R9 eoi", 1, 1, 8'h20, 0, 8'h00);

      // R5 masked request waits
      step("R5 edge on masked line 4", 0, 0, 8'h00, 0, 8'h10);
      chk("R5 masked stays quiet", {7'd0, int_req}, 8'h00);
      step("R5 unmask line 4", 1, 0, 8'h00, 0, 8'h10);
      chk("R5 unmasked presented", {7'd0, int_req}, 8'h01);
      step("R8 ack line 4", 0, 0, 8'h00, 1, 8'h10);
      chk("R8 vector 0x24", vec_out, 8'h24);
      // R6 held level does not retrigger
      step("R9 eoi line 4", 1, 1, 8'h20, 0, 8'h10);
      idle("R6 held high", 3);
      chk("R6 no retrigger", {7'd0, int_req}, 8'h00);

      // R4 setup without cascade byte, with mode byte
      step("R4 setup solo+mode", 1, 1, 8'h13, 0, 8'h00);
      step("R4 base 0x28", 1, 0, 8'h28, 0, 8'h00);
      step("R4 mode byte", 1, 0, 8'h01, 0, 8'h00);
      step("R4 mask write", 1, 0, 8'hF0, 0, 8'h00);
      step("R4 edge line 5 masked", 0, 0, 8'h00, 0, 8'h20);
      chk("R4 mask took effect", {7'd0, int_req}, 8'h00);
      // R4 setup with neither extra byte
      step("R4 setup solo only", 1, 1, 8'h12, 0, 8'h00);
      step("R4 base 0x40", 1, 0, 8'h40, 0, 8'h00);
      step("R4 mask right after base", 1, 0, 8'h00, 0, 8'h00);

      // R7 priority and in-service blocking
      step("R7 lines 2 and 5", 0, 0, 8'h00, 0, 8'h24);
      step("R7 grant line 2", 0, 0, 8'h00, 1, 8'h24);
      chk("R7 vector 0x42", vec_out, 8'h42);
      chk("R7 line 5 blocked", {7'd0, int_req}, 8'h00);
      step("R7 line 1 preempts", 0, 0, 8'h00, 0, 8'h26);
      chk("R7 higher line presented", {7'd0, int_req}, 8'h01);
      step("R7 grant line 1", 0, 0, 8'h00, 1, 8'h26);
      chk("R7 vector 0x41", vec_out, 8'h41);
      step("R9 other command ignored", 1, 1, 8'h60, 0, 8'h26);
      step("R8 ack while idle ignored", 0, 0, 8'h00, 1, 8'h26);
      step("R9 eoi releases line 1", 1, 1, 8'h20, 0, 8'h26);
      step("R9 eoi releases line 2", 1, 1, 8'h20, 0, 8'h26);
      chk("R9 line 5 now presented", {7'd0, int_req}, 8'h01);

      // random traffic
      for (int n = 0; n < 4000; n++) begin
         int r = $urandom % 100;
         logic [7:0] irq = irq_in;
         if ($urandom % 3 == 0) irq[$urandom % 8] = ~irq[$urandom % 8];
         if (r < 35)      step("R8 random ack", 0, 0, 8'h00, 1, irq);
         else if (r < 50) step("R9 random eoi", 1, 1, 8'h20, 0, irq);
         else if (r < 58) step("R5 random mask", 1, 0, 8'($urandom & $urandom & $urandom), 0, irq);
         else if (r < 60) step("R9 random command", 1, 1, 8'($urandom) & 8'hEF, 0, irq);
         else if (r < 61) step("R2 random setup", 1, 1, 8'h10 | 8'($urandom % 4), 0, irq);
         else if (r < 64 && m_state != 4) step("R4 random setup byte", 1, 0, 8'($urandom), 0, irq);
         else             step("R7 random idle", 0, 0, 8'h00, 0, irq);
      end

      done = 1;
      summary();
      $finish;
   end
endmodule